// File: doc/BRIEF.md
# Per-Channel Zero-Run Auto Mute

This block sits in a stereo PCM audio path. Samples arrive one at a time, each with a valid strobe, a one-bit channel tag and a 24-bit two's-complement value. For each channel the block counts how many exactly-zero samples have arrived in an unbroken run. When a channel's run reaches a fixed sample count (2048 by default), that channel's mute flag is raised. The delay is counted in samples, not in time, so it is the same at any sample rate. The two channels are counted separately.

A single non-zero sample on a channel ends that channel's run and drops its mute at once. That sample is passed through unchanged. The detector works only while the enable input is high. Pulling the enable low clears both run counters and both mute flags, and samples then flow through untouched. The sample path adds one register stage. The valid, channel and data outputs follow the inputs one clock later, and the mute flags change on the same edge.

Top module: `zero_run_mute`

## Requirements
- R1: After a synchronous active-high reset, both mute flags are 0 and the output valid is 0. A reset in the middle of a run discards the partial count, so a full new run of zero samples is needed before the channel mutes.
- R2: With enable high, a channel's mute flag (bit 0 for channel tag 0, bit 1 for tag 1) goes to 1 on the clock after that channel's 2048th consecutive zero sample. It stays 0 after the 2047th.
- R3: The run counter saturates at the threshold and does not wrap. A muted channel stays muted however many further zero samples arrive.
- R4: A sample tagged for one channel leaves the other channel's run count and mute flag unchanged. Zeros on one channel interleaved with non-zero samples on the other still build up the first channel's run.
- R5: A non-zero sample (any value other than 24'h000000, including 24'h800000) on a channel clears that channel's mute flag on the next clock. The sample appears unchanged at the output.
- R6: A non-zero sample before the threshold restarts that channel's run from zero, so a further full 2048 zeros are needed to mute.
- R7: A clock with enable low clears both run counters and both mute flags. If enable falls in the same cycle as a channel's 2048th zero, the clear wins.
- R8: While enable is low, no number of zero samples raises a mute flag.
- R9: The output valid, channel and data are the inputs delayed by one clock. The data of a sample on a muted channel is forced to zero.
- R10: Clocks without a valid sample change neither run count nor mute flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Zero-run detection enable |
| smp_vld_i | input | 1 | Input sample strobe |
| smp_ch_i | input | 1 | Channel tag of the input sample |
| smp_dat_i | input | 24 | Input sample value |
| out_vld_o | output | 1 | Output sample strobe |
| out_ch_o | output | 1 | Channel tag of the output sample |
| out_dat_o | output | 24 | Output sample after muting |
| mute_o | output | 2 | Mute flag per channel, bit index is channel tag |

## Verification
Two functions can act in the same cycle: the saturating step that raises a mute on the threshold-th zero, and the clear caused by the enable falling. The bench brings one channel to one zero short of the threshold. It then delivers the deciding zero sample in the very cycle the enable is pulled low. It judges the result by reading that channel's mute flag on the next clock, where it must be 0. After re-enabling, the bench also checks that a full run of 2048 zeros is needed again, which shows the counter really was cleared.

// File: rtl/zrm_pkg.sv
package zrm_pkg;

  localparam int unsigned ZRM_DW     = 24;
  localparam int unsigned ZRM_NCH    = 2;
  localparam int unsigned ZRM_THRESH = 2048;

  // Saturating advance of a zero-run length toward its limit.
  function automatic int unsigned zrm_next_run(input int unsigned run,
                                               input int unsigned limit);
    return (run >= limit) ? limit : run + 1;
  endfunction

endpackage

// File: rtl/zrm_zero_det.sv
module zrm_zero_det #(
  parameter int unsigned DW = 24
) (
  input  logic [DW-1:0] dat_i,
  output logic          is_zero_o
);
  assign is_zero_o = (dat_i == '0);
endmodule

// File: rtl/zrm_chan_track.sv
module zrm_chan_track
  import zrm_pkg::*;
#(
  parameter int unsigned THRESH = 2048,
  parameter int unsigned CW     = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          hit_i,
  input  logic          is_zero_i,
  output logic [CW-1:0] run_q_o,
  output logic          mute_q_o,
  output logic          mute_d_o
);
  logic [CW-1:0] run_d;
  logic [CW-1:0] run_step;

  assign run_step = CW'(zrm_next_run(32'(run_q_o), THRESH));

  always_comb begin
    run_d    = run_q_o;
    mute_d_o = mute_q_o;
    if (!en_i) begin
      run_d    = '0;
      mute_d_o = 1'b0;
    end else if (hit_i) begin
      if (is_zero_i) begin
        run_d    = run_step;
        mute_d_o = (run_step == CW'(THRESH));
      end else begin
        run_d    = '0;
        mute_d_o = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q_o  <= '0;
      mute_q_o <= 1'b0;
    end else begin
      run_q_o  <= run_d;
      mute_q_o <= mute_d_o;
    end
  end
endmodule

// File: rtl/zrm_out_stage.sv
module zrm_out_stage #(
  parameter int unsigned DW  = 24,
  parameter int unsigned CHW = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           vld_i,
  input  logic [CHW-1:0] ch_i,
  input  logic [DW-1:0]  dat_i,
  input  logic           force_zero_i,
  output logic           vld_o,
  output logic [CHW-1:0] ch_o,
  output logic [DW-1:0]  dat_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      ch_o  <= '0;
      dat_o <= '0;
    end else begin
      vld_o <= vld_i;
      ch_o  <= ch_i;
      dat_o <= force_zero_i ? '0 : dat_i;
    end
  end
endmodule

// File: rtl/zero_run_mute.sv
module zero_run_mute
  import zrm_pkg::*;
#(
  parameter int unsigned DW     = ZRM_DW,
  parameter int unsigned NCH    = ZRM_NCH,
  parameter int unsigned THRESH = ZRM_THRESH,
  localparam int unsigned CHW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned CW    = $clog2(THRESH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en_i,
  input  logic           smp_vld_i,
  input  logic [CHW-1:0] smp_ch_i,
  input  logic [DW-1:0]  smp_dat_i,
  output logic           out_vld_o,
  output logic [CHW-1:0] out_ch_o,
  output logic [DW-1:0]  out_dat_o,
  output logic [NCH-1:0] mute_o
);
  // Named internal events, visible to the bound checker.
  logic                    smp_is_zero;
  logic [NCH-1:0]          chan_hit;
  logic [NCH-1:0]          mute_next;
  logic [NCH-1:0][CW-1:0]  run_cnt;
  logic                    force_zero;

  zrm_zero_det #(.DW(DW)) u_zdet (
    .dat_i     (smp_dat_i),
    .is_zero_o (smp_is_zero)
  );

  for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
    assign chan_hit[gi] = smp_vld_i && (smp_ch_i == CHW'(gi));

    zrm_chan_track #(.THRESH(THRESH), .CW(CW)) u_trk (
      .clk       (clk),
      .rst       (rst),
      .en_i      (en_i),
      .hit_i     (chan_hit[gi]),
      .is_zero_i (smp_is_zero),
      .run_q_o   (run_cnt[gi]),
      .mute_q_o  (mute_o[gi]),
      .mute_d_o  (mute_next[gi])
    );
  end

  assign force_zero = |(mute_next & chan_hit);

  zrm_out_stage #(.DW(DW), .CHW(CHW)) u_out (
    .clk          (clk),
    .rst          (rst),
    .vld_i        (smp_vld_i),
    .ch_i         (smp_ch_i),
    .dat_i        (smp_dat_i),
    .force_zero_i (force_zero),
    .vld_o        (out_vld_o),
    .ch_o         (out_ch_o),
    .dat_o        (out_dat_o)
  );
endmodule

// File: rtl/zrm_checker.sv
module zrm_checker #(
  parameter int unsigned DW     = 24,
  parameter int unsigned NCH    = 2,
  parameter int unsigned THRESH = 2048,
  parameter int unsigned CHW    = 1,
  parameter int unsigned CW     = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   en_i,
  input logic                   smp_vld_i,
  input logic [CHW-1:0]         smp_ch_i,
  input logic [DW-1:0]          smp_dat_i,
  input logic                   out_vld_o,
  input logic [CHW-1:0]         out_ch_o,
  input logic [DW-1:0]          out_dat_o,
  input logic [NCH-1:0]         mute_o,
  input logic [NCH-1:0][CW-1:0] run_cnt
);

  // R7: a disabled cycle leaves every counter and flag cleared.
  p_enable_clear_r7: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (mute_o == '0 && run_cnt == '0));

  // R10: idle cycles hold all state.
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (en_i && !smp_vld_i) |=> ($stable(mute_o) && $stable(run_cnt)));

  // R9: the output of a muted channel carries zero.
  p_muted_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (out_vld_o && mute_o[out_ch_o]) |-> (out_dat_o == '0));

  // R9: strobe and tag are delayed by one clock.
  p_delay_r9: assert property (@(posedge clk) disable iff (rst)
    smp_vld_i |=> (out_vld_o && out_ch_o == $past(smp_ch_i)));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R3: run length never passes the threshold.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      run_cnt[c] <= CW'(THRESH));

    // R2: a raised mute sits on a full run.
    p_mute_full_run_r2: assert property (@(posedge clk) disable iff (rst)
      mute_o[c] |-> (run_cnt[c] == CW'(THRESH)));

    // R2: a mute only rises after a zero sample on its own channel.
    p_rise_cause_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(mute_o[c]) |-> $past(en_i && smp_vld_i &&
                                 smp_ch_i == CHW'(c) && smp_dat_i == '0));

    // R5: a non-zero sample releases the mute and passes through.
    p_release_r5: assert property (@(posedge clk) disable iff (rst)
      (en_i && smp_vld_i && smp_ch_i == CHW'(c) && smp_dat_i != '0) |=>
        (!mute_o[c] && out_dat_o == $past(smp_dat_i)));

    // R4: samples for another channel leave this one alone.
    p_other_chan_r4: assert property (@(posedge clk) disable iff (rst)
      (en_i && smp_vld_i && smp_ch_i != CHW'(c)) |=>
        ($stable(run_cnt[c]) && $stable(mute_o[c])));
  end
endmodule

bind zero_run_mute zrm_checker #(
  .DW(DW), .NCH(NCH), .THRESH(THRESH), .CHW(CHW), .CW(CW)
) u_chk (.*);

// File: tb/tb_zero_run_mute.sv
module tb_zero_run_mute;
  localparam int T = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_i = 1'b1;
  logic        smp_vld_i = 1'b0;
  logic        smp_ch_i = 1'b0;
  logic [23:0] smp_dat_i = '0;
  logic        out_vld_o;
  logic        out_ch_o;
  logic [23:0] out_dat_o;
  logic [1:0]  mute_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  zero_run_mute dut (
    .clk(clk), .rst(rst), .en_i(en_i), .smp_vld_i(smp_vld_i),
    .smp_ch_i(smp_ch_i), .smp_dat_i(smp_dat_i), .out_vld_o(out_vld_o),
    .out_ch_o(out_ch_o), .out_dat_o(out_dat_o), .mute_o(mute_o)
  );

  // {channel, sample}; mute never reached, so output mirrors input.
  localparam logic [24:0] VEC [0:7] = '{
    {1'b0, 24'h123456}, {1'b1, 24'h000000}, {1'b1, 24'hFFFFFF},
    {1'b0, 24'h000000}, {1'b0, 24'h800000}, {1'b1, 24'h7FFFFF},
    {1'b0, 24'h000001}, {1'b1, 24'h00A5A5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic ch, input logic [23:0] d);
    smp_ch_i  = ch;
    smp_dat_i = d;
    smp_vld_i = 1'b1;
    @(negedge clk);
    smp_vld_i = 1'b0;
  endtask

  task automatic zeros(input logic ch, input int n);
    for (int i = 0; i < n; i++) push(ch, 24'h0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1: reset state
    chk("R1 mute", 32'(mute_o), 0);
    chk("R1 out_vld", 32'(out_vld_o), 0);

    // R9: pass-through table
    for (int k = 0; k < 8; k++) begin
      push(VEC[k][24], VEC[k][23:0]);
      chk("R9 vld", 32'(out_vld_o), 1);
      chk("R9 ch", 32'(out_ch_o), 32'(VEC[k][24]));
      chk("R9 dat", 32'(out_dat_o), 32'(VEC[k][23:0]));
    end
    idle(1);
    chk("R9 vld drop", 32'(out_vld_o), 0);

    // R2: threshold boundary
    zeros(0, T - 1);
    chk("R2 below", 32'(mute_o[0]), 0);
    push(0, 24'h0);
    chk("R2 at", 32'(mute_o[0]), 1);
    chk("R9 muted dat", 32'(out_dat_o), 0);

    // R3: saturation
    zeros(0, T + 5);
    chk("R3 held", 32'(mute_o[0]), 1);

    // R10: idle cycles keep a partial run
    zeros(1, T - 1);
    chk("R10 partial", 32'(mute_o[1]), 0);
    idle(10);
    chk("R10 idle", 32'(mute_o), 32'b01);
    push(1, 24'h0);
    chk("R10 resume", 32'(mute_o[1]), 1);

    // R5: release with pass-through; R4 other channel untouched
    push(0, 24'h800000);
    chk("R5 release", 32'(mute_o[0]), 0);
    chk("R5 dat", 32'(out_dat_o), 32'h800000);
    chk("R4 other held", 32'(mute_o[1]), 1);

    // R4: interleaved traffic
    push(1, 24'h000007);
    chk("R5 release ch1", 32'(mute_o[1]), 0);
    for (int i = 0; i < T; i++) begin
      push(0, 24'h0);
      push(1, 24'h000009);
      if (i == T - 2) chk("R4 before", 32'(mute_o[0]), 0);
    end
    chk("R4 interleaved", 32'(mute_o), 32'b01);

    // R6: a non-zero sample restarts the run
    push(0, 24'h000005);
    zeros(0, T - 1);
    push(0, 24'h000003);
    zeros(0, T - 1);
    chk("R6 restarted", 32'(mute_o[0]), 0);
    push(0, 24'h0);
    chk("R6 full run", 32'(mute_o[0]), 1);

    // R7: disable clears state
    en_i = 1'b0;
    idle(1);
    chk("R7 clear", 32'(mute_o), 0);
    en_i = 1'b1;
    zeros(0, T - 1);
    chk("R7 counter cleared", 32'(mute_o[0]), 0);
    push(0, 24'h0);
    chk("R7 remute", 32'(mute_o[0]), 1);

    // R7: enable falls on the deciding zero sample
    zeros(1, T - 1);
    en_i = 1'b0;
    push(1, 24'h0);
    chk("R7 clear wins", 32'(mute_o[1]), 0);
    en_i = 1'b1;
    zeros(1, T - 1);
    chk("R7 clear wins count", 32'(mute_o[1]), 0);
    push(1, 24'h0);
    chk("R7 clear wins remute", 32'(mute_o[1]), 1);

    // R8: no muting while disabled
    en_i = 1'b0;
    zeros(0, T + 3);
    chk("R8 no mute", 32'(mute_o), 0);
    push(1, 24'hABCDEF);
    chk("R8 pass", 32'(out_dat_o), 32'hABCDEF);
    en_i = 1'b1;

    // R1: reset mid-run discards partial count
    zeros(0, T - 5);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    chk("R1 mid reset mute", 32'(mute_o), 0);
    chk("R1 mid reset vld", 32'(out_vld_o), 0);
    zeros(0, T - 1);
    chk("R1 run restarted", 32'(mute_o[0]), 0);
    push(0, 24'h0);
    chk("R1 remute", 32'(mute_o[0]), 1);

    done = 1'b1;
    summary();
  end
endmodule